// File: doc/BRIEF.md
# Atomic Set/Clear General-Purpose I/O Port

This block is a general-purpose I/O port of parameterised width (32 bits by default). It sits on a local register bus that completes every access in one cycle. Software chooses a direction per pin, and the port drives each pin's output level and output-enable toward the pin multiplexer from registers.

The output latch can be written whole, or changed bit by bit through a set-write register and a clear-write register. Only the bits written as one are touched, so no read-modify-write is needed. Reads keep two things apart: the latched output value, and the live level of every pin. The live level is taken through a two-flop synchronizer.

Each bus write carries a byte-lane mask. Bit b of the mask enables data bits 8b+7..8b for that write.

Top module: `gpio_setclr_port`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `pin_oe`, `pin_out` and `bus_rdata` are all zero, and the direction and output registers read back as zero.
- R2: Writing the direction register (offset 0) stores one bit per pin, where 1 means output. `pin_oe` shows the new value on the cycle after the write, and a read of offset 0 returns it.
- R3: Writing the output register (offset 1) replaces the latch. `pin_out` shows it on the cycle after the write, and a read of offset 1 returns the latch.
- R4: Writing the set register (offset 2) sets every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R5: Writing the clear register (offset 3) clears every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R6: Bit b of `bus_bmask` enables data bits 8b+7..8b of a write to offsets 0 to 3. Bits in disabled lanes keep their value.
- R7: A read of the pin-level register (offset 4) returns `pin_in` as it was sampled three clock edges before the read data appears. A level held for three edges is therefore read correctly, for output pins and input pins alike.
- R8: Read data appears on `bus_rdata` one cycle after the read request and holds until the next read. Offsets 2, 3, 5, 6 and 7 read as zero.
- R9: Writes to offsets 4 to 7 change neither register. The output latch is written and drives `pin_out` whatever the direction of the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_bmask | input | WIDTH/8 | Byte-lane write enables |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Live pin levels |
| pin_out | output | WIDTH | Output level per pin |
| pin_oe | output | WIDTH | Output enable per pin |

## Verification
The hardest case to reach from the ports is a pin-level read that proves the synchronizer delay while some pins are outputs looping back. In that case the read value mixes the latch with external levels.

The bench loops the pins back through a pad model: `pin_in` equals `pin_out` where `pin_oe` is set, and a bench-driven level elsewhere. It then changes the directions, the latch and the external levels, and reads offset 4 both before and after the three-edge settling time.

Partial-lane set and clear writes are also aimed at latch patterns in which every bit outside the enabled lanes would betray a wrongly masked write.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int ADDR_W = 3;
  localparam int MAX_W  = 64;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_SET  = 3'd2,
    REG_CLR  = 3'd3,
    REG_PINS = 3'd4
  } reg_ofs_e;

  // widen a byte-lane mask into a bit mask
  function automatic logic [MAX_W-1:0] lane_expand(input logic [MAX_W/8-1:0] bm);
    logic [MAX_W-1:0] m;
    for (int i = 0; i < MAX_W/8; i++) m[i*8 +: 8] = {8{bm[i]}};
    return m;
  endfunction
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
  import gpio_sc_pkg::*;
#(
  parameter int W = 32,
  localparam int LANES = W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [LANES-1:0]  bmask,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q
);
  logic [W-1:0] lm;
  logic [W-1:0] wm;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lm[g*8 +: 8] = {8{bmask[g]}};
  end

  assign wm = wdata & lm;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_DIR: dir_q <= (dir_q & ~lm) | wm;
        REG_OUT: out_q <= (out_q & ~lm) | wm;
        REG_SET: out_q <= out_q | wm;
        REG_CLR: out_q <= out_q & ~wm;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sc_rdmux.sv
module gpio_sc_rdmux
  import gpio_sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      out_q,
  input  logic [W-1:0]      lvl_q,
  output logic [W-1:0]      rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        REG_DIR:  rdata <= dir_q;
        REG_OUT:  rdata <= out_q;
        REG_PINS: rdata <= lvl_q;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_sc_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LANES = WIDTH / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [LANES-1:0]  bus_bmask,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic [WIDTH-1:0] dir_q, out_q, lvl_q;
  logic             wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_sc_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_q)
  );

  gpio_sc_regs #(.W(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .bmask(bus_bmask), .dir_q(dir_q), .out_q(out_q)
  );

  gpio_sc_rdmux #(.W(WIDTH)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(bus_addr),
    .dir_q(dir_q), .out_q(out_q), .lvl_q(lvl_q), .rdata(bus_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk
  import gpio_sc_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LANES = WIDTH / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [LANES-1:0]  bus_bmask,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_in,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe
);
  logic [MAX_W-1:0] full_m;
  logic [WIDTH-1:0] wm;
  logic             was_rst = 1'b0;
  logic [1:0]       age = '0;

  assign full_m = lane_expand((MAX_W/8)'(bus_bmask));
  assign wm     = bus_wdata & full_m[WIDTH-1:0];

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1: outputs are cleared on the cycle after reset
  always @(posedge clk) begin
    if (was_rst)
      a_r1_reset_clear: assert (pin_oe == '0 && pin_out == '0 && bus_rdata == '0);
  end

  // R2: direction changes only through a write to offset 0
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == REG_DIR) |=> $stable(pin_oe));

  // R4: the set write raises the written ones and keeps the other bits
  a_r4_set_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == REG_SET) |=>
      (pin_out == ($past(pin_out) | $past(wm))));

  // R5: the clear write drops the written ones and keeps the other bits
  a_r5_clr_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == REG_CLR) |=>
      (pin_out == ($past(pin_out) & ~$past(wm))));

  // R8: read data holds between reads
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  // R9: the latch does not move on a cycle with no latch write
  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr inside {REG_OUT, REG_SET, REG_CLR}) |=> $stable(pin_out));

  if (SYNC_STAGES == 2) begin : g_lvl
    // R7: pin-level reads lag pin_in by three edges
    a_r7_pin_delay: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && bus_sel && !bus_wr && bus_addr == REG_PINS) |=>
        (bus_rdata == $past(pin_in, 3)));
  end
endmodule

bind gpio_setclr_port gpio_sc_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_bmask(bus_bmask), .bus_rdata(bus_rdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_setclr_port_tb_top.sv
module gpio_setclr_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [3:0]    bus_bmask = '0;
  logic [W-1:0]  bus_rdata, pin_out, pin_oe, pin_in;
  logic [W-1:0]  ext_lvl = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pad model: driven pins loop back, others follow the external level
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

  gpio_setclr_port dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_bmask(bus_bmask), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [3:0] m);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_bmask = m;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 rdata", bus_rdata, '0);
    rd(3'd0, v); check("R1 dir read", v, '0);
    rd(3'd1, v); check("R1 out read", v, '0);
  endtask

  task automatic t_dir();
    logic [W-1:0] v;
    wr(3'd0, 32'hA5A5_0F0F, 4'hF);
    check("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);
    rd(3'd0, v); check("R2 dir read", v, 32'hA5A5_0F0F);
    wr(3'd0, 32'h0000_0000, 4'hF);
    check("R2 dir cleared", pin_oe, '0);
  endtask

  task automatic t_out();
    logic [W-1:0] v;
    wr(3'd1, 32'h1234_5678, 4'hF);
    check("R9 pin_out with all inputs", pin_out, 32'h1234_5678);
    rd(3'd1, v); check("R3 out read", v, 32'h1234_5678);
    wr(3'd1, 32'hFFFF_0000, 4'hF);
    check("R3 out rewrite", pin_out, 32'hFFFF_0000);
  endtask

  task automatic t_set_clr();
    wr(3'd1, 32'hF0F0_F0F0, 4'hF);
    wr(3'd2, 32'h0101_0101, 4'hF);
    check("R4 set", pin_out, 32'hF1F1_F1F1);
    wr(3'd2, 32'h0000_0000, 4'hF);
    check("R4 set zeros no change", pin_out, 32'hF1F1_F1F1);
    wr(3'd3, 32'h8000_0011, 4'hF);
    check("R5 clear", pin_out, 32'h71F1_F1E0);
    wr(3'd3, 32'h0000_0000, 4'hF);
    check("R5 clear zeros no change", pin_out, 32'h71F1_F1E0);
  endtask

  task automatic t_mask();
    logic [W-1:0] v;
    wr(3'd1, 32'h0000_0000, 4'hF);
    wr(3'd2, 32'hFFFF_FFFF, 4'b0101);
    check("R6 set lanes 0,2", pin_out, 32'h00FF_00FF);
    wr(3'd3, 32'hFFFF_FFFF, 4'b0001);
    check("R6 clear lane 0", pin_out, 32'h00FF_0000);
    wr(3'd1, 32'hAABB_CCDD, 4'b1000);
    check("R6 out lane 3", pin_out, 32'hAAFF_0000);
    wr(3'd0, 32'hFFFF_FFFF, 4'b0010);
    rd(3'd0, v); check("R6 dir lane 1", v, 32'h0000_FF00);
    wr(3'd0, 32'h0, 4'hF);
  endtask

  task automatic t_pins();
    logic [W-1:0] v;
    wr(3'd1, 32'h0000_A500, 4'hF);
    wr(3'd0, 32'h0000_FF00, 4'hF);
    @(negedge clk); ext_lvl = 32'h1234_00C3;
    repeat (3) @(negedge clk);
    rd(3'd4, v); check("R7 mixed levels", v, 32'h1234_A5C3);
    // the change is captured at the next edge, so the read registered two edges later still sees the old level
    ext_lvl = 32'hFFFF_00FF;
    rd(3'd4, v); check("R7 old level before settling", v, 32'h1234_A5C3);
    repeat (3) @(negedge clk);
    rd(3'd4, v); check("R7 new level", v, 32'hFFFF_A5FF);
    wr(3'd0, 32'h0, 4'hF);
  endtask

  task automatic t_map();
    logic [W-1:0] v, o;
    rd(3'd1, o);
    rd(3'd2, v); check("R8 set reads zero", v, '0);
    rd(3'd3, v); check("R8 clr reads zero", v, '0);
    rd(3'd6, v); check("R8 unmapped reads zero", v, '0);
    wr(3'd4, 32'hFFFF_FFFF, 4'hF);
    wr(3'd7, 32'hFFFF_FFFF, 4'hF);
    check("R9 pins/unmapped write: out", pin_out, o);
    check("R9 pins/unmapped write: oe", pin_oe, '0);
    rd(3'd1, v);
    repeat (3) @(negedge clk);
    check("R8 rdata holds", bus_rdata, o);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dir();
    t_out();
    t_set_clr();
    t_mask();
    t_pins();
    t_map();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule